// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 24-bit bus address into one of several active-low chip-select lines, one line per memory space. Every space has a base byte, a mask byte and a control byte, all written and read back over a small register port. A base byte sets address bits 23..16 of the space's origin; the lower origin bits are zero. A mask byte frees a band of address bits between 20 and 8 from the comparison, which sets the size of the space.

On a clock edge where the address strobe is high, the block compares the address with every enabled space. It then drives low the chip-select of the lowest-numbered space that matched, or raises a no-hit flag if none did. The outputs are registered, so they follow the strobed address by one clock.

One space, chosen by a parameter, can be switched to cover the whole 16-Mbyte range. In that mode it acts as a fallback that loses to every other space.

Top module: `csSpaceDecoder`

## Requirements
- R1: After reset all chip-selects are high, the no-hit flag is low, and every register reads 0, so no space is enabled.
- R2: Register address is {space, field}, with field 0 the base byte, 1 the mask byte, 2 the control byte and 3 reading 0. Control bit 0 enables the space. Control bit 1 selects whole-range mode, is stored only in the fallback space (index 2 by default) and reads 0 in any other space. Reads are combinational from the register address.
- R3: A space matches when address bits 23..16 equal its base byte, and address bits 15..8 are zero, except at positions freed by the mask. With base 01h and mask 07h the space covers exactly 010000h to 01FFFFh.
- R4: Mask bits 7..2 free address bits 20..15 one for one, mask bit 1 frees address bits 14..9 together, and mask bit 0 frees address bit 8. Address bits 7..0 are never compared, and bits 23..21 are always compared.
- R5: A base that is not a multiple of the block size decodes exactly as the masked comparison dictates. For example, base 01h with mask 0Fh matches 000000h.
- R6: When several spaces match, only the lowest-numbered chip-select goes low. At most one chip-select is low at any time.
- R7: An enabled fallback space in whole-range mode matches every address, but only when no other enabled space matches. A higher-numbered space therefore beats it.
- R8: The outputs change on the clock edge that samples the strobe high. While the strobe is low, the next edge drives all chip-selects high and the no-hit flag low.
- R9: When the strobe is high and no space matches, the next edge raises the no-hit flag and leaves all chip-selects high.
- R10: A space whose enable bit is 0 never drives its chip-select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | IDX_W+2 | Register select {space, field} |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| addrValid | input | 1 | Address strobe |
| busAddr | input | 24 | Bus address |
| csN | output | NUM_SPACES | Active-low chip-selects |
| noMatch | output | 1 | High for one cycle after a strobed address that hit no space |

## Verification
The bench targets these corner cases and the faulty behaviour each one catches:
- **Mask bit mapping.** A design that mapped mask bit 1 to a single address bit, or compared the low address byte, would miss addresses such as 407E00h or 4000FFh.
- **Misaligned base.** A design that aligned a misaligned base would fail to select 000000h for base 01h with mask 0Fh.
- **Overlap.** A design with the priority reversed would drop two chip-selects, or the wrong one, when spaces overlap.
- **Fallback.** A fallback treated as an ordinary space would win over space 3.
- **Ctrl bit 1 on other spaces.** A design that stored this bit in every space would read back a value that is not zero.
- **Random traffic.** A long random mix of writes and accesses is compared cycle by cycle against a behavioural model, which catches any skew in the output timing.

// File: rtl/csDecPkg.sv
package csDecPkg;
  localparam int ADDR_W = 24;
  localparam logic [1:0] FIELD_BASE = 2'd0;
  localparam logic [1:0] FIELD_MASK = 2'd1;
  localparam logic [1:0] FIELD_CTRL = 2'd2;

  typedef struct packed {
    logic wrBase;
    logic wrMask;
    logic wrCtrl;
  } spaceWr_t;

  // Spread the 8-bit mask byte over address bits 23..8 (index 0 = bit 8).
  function automatic logic [15:0] spreadMask(input logic [7:0] m);
    logic [15:0] r;
    r = '0;
    r[0] = m[0];
    r[6:1] = {6{m[1]}};
    r[12:7] = m[7:2];
    return r;
  endfunction
endpackage

// File: rtl/csDecCtrl.sv
module csDecCtrl
  import csDecPkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int IDX_W = 2
) (
  input  logic           regWrEn,
  input  logic [IDX_W+1:0] regAddr,
  input  logic           addrValid,
  output spaceWr_t       wrStb [NUM_SPACES],
  output logic           lookupEn
);
  logic [IDX_W-1:0] selSpace;
  logic [1:0] selField;

  assign selSpace = regAddr[IDX_W+1:2];
  assign selField = regAddr[1:0];
  assign lookupEn = addrValid;

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_stb
    logic hitSpace;
    assign hitSpace = regWrEn && (selSpace == IDX_W'(i));
    assign wrStb[i].wrBase = hitSpace && (selField == FIELD_BASE);
    assign wrStb[i].wrMask = hitSpace && (selField == FIELD_MASK);
    assign wrStb[i].wrCtrl = hitSpace && (selField == FIELD_CTRL);
  end
endmodule

// File: rtl/csDecDatapath.sv
module csDecDatapath
  import csDecPkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CATCH_IDX = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  spaceWr_t         wrStb [NUM_SPACES],
  input  logic [7:0]       regWrData,
  input  logic [IDX_W+1:0] regAddr,
  output logic [7:0]       regRdData,
  input  logic             lookupEn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [NUM_SPACES-1:0] csN,
  output logic             noMatch
);
  logic [7:0] baseReg [NUM_SPACES];
  logic [7:0] maskReg [NUM_SPACES];
  logic [NUM_SPACES-1:0] enReg;
  logic wholeReg;
  logic [NUM_SPACES-1:0] normHit;
  logic [NUM_SPACES-1:0] pick;
  logic catchHit;

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_space
    logic [15:0] diff;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[i] <= '0;
        maskReg[i] <= '0;
        enReg[i] <= 1'b0;
      end else begin
        if (wrStb[i].wrBase) baseReg[i] <= regWrData;
        if (wrStb[i].wrMask) maskReg[i] <= regWrData;
        if (wrStb[i].wrCtrl) enReg[i] <= regWrData[0];
      end
    end
    assign diff = (busAddr[23:8] ^ {baseReg[i], 8'h00}) & ~spreadMask(maskReg[i]);
    if (i == CATCH_IDX) begin : g_catch
      assign normHit[i] = enReg[i] && !wholeReg && (diff == '0);
    end else begin : g_norm
      assign normHit[i] = enReg[i] && (diff == '0);
    end
    // R10: a disabled space never drives its select low
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !enReg[i] |=> csN[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wholeReg <= 1'b0;
    else if (wrStb[CATCH_IDX].wrCtrl) wholeReg <= regWrData[1];
  end

  assign catchHit = enReg[CATCH_IDX] && wholeReg;

  always_comb begin
    logic found;
    found = 1'b0;
    pick = '0;
    for (int i = 0; i < NUM_SPACES; i++) begin
      if (!found && normHit[i]) begin
        pick[i] = 1'b1;
        found = 1'b1;
      end
    end
    if (!found && catchHit) pick[CATCH_IDX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN <= '1;
      noMatch <= 1'b0;
    end else begin
      csN <= lookupEn ? ~pick : '1;
      noMatch <= lookupEn && (pick == '0);
    end
  end

  logic [IDX_W-1:0] rdSpace;
  assign rdSpace = regAddr[IDX_W+1:2];

  always_comb begin
    regRdData = '0;
    if (int'(rdSpace) < NUM_SPACES) begin
      case (regAddr[1:0])
        FIELD_BASE: regRdData = baseReg[rdSpace];
        FIELD_MASK: regRdData = maskReg[rdSpace];
        FIELD_CTRL: regRdData = {6'b0, (int'(rdSpace) == CATCH_IDX) && wholeReg, enReg[rdSpace]};
        default:    regRdData = '0;
      endcase
    end
  end

  a_r6_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupEn |=> (csN == '1 && !noMatch));
  a_r8_strobe_answers: assert property (@(posedge clk) disable iff (!rstN)
    lookupEn |=> (csN != '1 || noMatch));
  a_r9_flag_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> csN == '1);
endmodule

// File: rtl/csSpaceDecoder.sv
module csSpaceDecoder
  import csDecPkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CATCH_IDX = 2,
  localparam int IDX_W = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W+1:0] regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             addrValid,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [NUM_SPACES-1:0] csN,
  output logic             noMatch
);
  spaceWr_t wrStb [NUM_SPACES];
  logic lookupEn;

  csDecCtrl #(.NUM_SPACES(NUM_SPACES), .IDX_W(IDX_W)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .addrValid(addrValid),
    .wrStb(wrStb), .lookupEn(lookupEn)
  );

  csDecDatapath #(.NUM_SPACES(NUM_SPACES), .CATCH_IDX(CATCH_IDX), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .regWrData(regWrData),
    .regAddr(regAddr), .regRdData(regRdData), .lookupEn(lookupEn),
    .busAddr(busAddr), .csN(csN), .noMatch(noMatch)
  );
endmodule

// File: tb/csSpaceDecoder_tb_top.sv
module csSpaceDecoder_tb_top;
  localparam int N = 4;
  localparam int CATCH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic addrValid = 1'b0;
  logic [23:0] busAddr = '0;
  logic [N-1:0] csN;
  logic noMatch;

  always #4 clk = ~clk;

  csSpaceDecoder dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .addrValid(addrValid),
    .busAddr(busAddr), .csN(csN), .noMatch(noMatch)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string curReq = "R1";
  logic [7:0] mBase [N];
  logic [7:0] mMask [N];
  logic mEn [N];
  logic mWhole = 1'b0;
  logic [N-1:0] expCs = '1;
  logic expNm = 1'b0;

  function automatic bit freed(input logic [7:0] m, input int b);
    if (b >= 15 && b <= 20) return m[b - 13];
    if (b >= 9 && b <= 14) return m[1];
    if (b == 8) return m[0];
    return 1'b0;
  endfunction

  function automatic bit spaceHit(input int i, input logic [23:0] a);
    for (int b = 8; b < 24; b++) begin
      logic want;
      want = (b >= 16) ? mBase[i][b-16] : 1'b0;
      if (!freed(mMask[i], b) && a[b] !== want) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic refDecode(input logic [23:0] a, output logic [N-1:0] cs, output logic nm);
    cs = '1;
    for (int i = 0; i < N; i++) begin
      if (cs == '1 && mEn[i] && !(i == CATCH && mWhole) && spaceHit(i, a)) cs[i] = 1'b0;
    end
    if (cs == '1 && mEn[CATCH] && mWhole) cs[CATCH] = 1'b0;
    nm = (cs == '1);
  endtask

  task automatic checkOut();
    compared++;
    if (csN !== expCs || noMatch !== expNm) begin
      mismatched++;
      $display("FAIL %s: csN=%b noMatch=%b expected csN=%b noMatch=%b", curReq, csN, noMatch, expCs, expNm);
    end
  endtask

  task automatic step(input logic v, input logic [23:0] a, input logic we,
                      input logic [3:0] wa, input logic [7:0] wd);
    @(negedge clk);
    checkOut();
    addrValid = v; busAddr = a; regWrEn = we; regAddr = wa; regWrData = wd;
    if (v) refDecode(a, expCs, expNm);
    else begin expCs = '1; expNm = 1'b0; end
    if (we) begin
      case (wa[1:0])
        2'd0: mBase[wa[3:2]] = wd;
        2'd1: mMask[wa[3:2]] = wd;
        2'd2: begin mEn[wa[3:2]] = wd[0]; if (int'(wa[3:2]) == CATCH) mWhole = wd[1]; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int sp, input int f, input logic [7:0] d);
    step(0, '0, 1, {2'(sp), 2'(f)}, d);
  endtask

  task automatic acc(input logic [23:0] a);
    step(1, a, 0, '0, '0);
  endtask

  task automatic rd(input int sp, input int f, input logic [7:0] exp);
    step(0, '0, 0, {2'(sp), 2'(f)}, '0);
    #1;
    compared++;
    if (regRdData !== exp) begin
      mismatched++;
      $display("FAIL %s: read sp%0d f%0d got %h expected %h", curReq, sp, f, regRdData, exp);
    end
  endtask

  task automatic cfg(input int sp, input logic [7:0] b, input logic [7:0] m, input logic [7:0] c);
    wr(sp, 0, b); wr(sp, 1, m); wr(sp, 2, c);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mBase[i] = '0; mMask[i] = '0; mEn[i] = 1'b0; end
    repeat (3) @(negedge clk);
    checkOut();  // R1: outputs quiet in reset
    rstN = 1'b1;
    curReq = "R1";
    for (int s = 0; s < N; s++) for (int f = 0; f < 4; f++) rd(s, f, 8'h00);
    acc(24'h000000);  // R1: nothing enabled -> no hit
    curReq = "R2";
    cfg(1, 8'hA5, 8'h3C, 8'h03);
    rd(1, 0, 8'hA5); rd(1, 1, 8'h3C); rd(1, 2, 8'h01); rd(1, 3, 8'h00);
    wr(2, 2, 8'h03); rd(2, 2, 8'h03);
    cfg(1, 8'h00, 8'h00, 8'h00); wr(2, 2, 8'h00); rd(2, 2, 8'h00);
    curReq = "R3";
    cfg(0, 8'h01, 8'h07, 8'h01);
    acc(24'h010000); acc(24'h01FFFF); acc(24'h020000); acc(24'h00FFFF); acc(24'h810000);
    curReq = "R4";
    wr(0, 2, 8'h00);
    cfg(1, 8'h40, 8'h02, 8'h01);
    acc(24'h407E00); acc(24'h400100); acc(24'h408000); acc(24'h4000FF);
    wr(1, 1, 8'h01); acc(24'h400100); acc(24'h400200);
    cfg(1, 8'h00, 8'hFF, 8'h01); acc(24'h1FFFFF); acc(24'h200000); acc(24'hE00000);
    curReq = "R5";
    cfg(1, 8'h01, 8'h0F, 8'h01);
    acc(24'h000000); acc(24'h01FFFF); acc(24'h020000);
    curReq = "R6";
    cfg(0, 8'h00, 8'hFF, 8'h01); cfg(1, 8'h00, 8'hFF, 8'h01);
    acc(24'h123456); acc(24'h000000);
    curReq = "R10";
    wr(0, 2, 8'h00); acc(24'h123456);
    wr(1, 2, 8'h00); acc(24'h123456);
    curReq = "R7";
    cfg(2, 8'h55, 8'h00, 8'h03);
    acc(24'h000000); acc(24'hFFFFFF);
    cfg(3, 8'h80, 8'h07, 8'h01);
    acc(24'h80ABCD); acc(24'h90ABCD);
    cfg(0, 8'h90, 8'h07, 8'h01); acc(24'h90ABCD);
    curReq = "R8";
    step(0, 24'h80ABCD, 0, '0, '0); step(0, 24'h000000, 0, '0, '0);
    curReq = "R9";
    wr(0, 2, 8'h00); wr(2, 2, 8'h00); wr(3, 2, 8'h00);
    acc(24'h80ABCD); acc(24'h550000);
    curReq = "R6";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) wr($urandom_range(0, 3), $urandom_range(0, 3), 8'($urandom));
      else if (r < 9) begin
        logic [23:0] a;
        a = 24'($urandom);
        if ($urandom_range(0, 1) == 1) a[23:16] = mBase[$urandom_range(0, 3)];
        acc(a);
      end else step(0, 24'($urandom), 0, '0, '0);
    end
    step(0, '0, 0, '0, '0);
    finishRun();
  end
endmodule